// File: doc/BRIEF.md
# Serial CAN Frame Check Sequence Unit

This block produces and verifies the 15-bit frame check sequence of a CAN frame, one destuffed bit per valid strobe. A frame begins with a synchronous clear. While the frame's protected bits stream past (start-of-frame bit, then arbitration, control and data fields), the caller selects the accumulate phase and pulses the valid strobe once per real bit. Stuff bits are filtered by keeping the strobe low.

When the data field ends, a transmitter switches to the shift-out phase. It sends `crcBitOut` on the bus and pulses the strobe once per bit, so the sequence leaves most significant bit first. A receiver switches to the compare phase instead and presents each received CRC bit on `crcBitIn`. The same register shifts out in both cases. Any bit that disagrees sets a sticky error flag, which the frame parser samples at the CRC delimiter.

Top module: `frame_crc15`

## Requirements
- R1: After reset, `crcBitOut` and `crcError` are both 0 and the register holds zero.
- R2: A cycle with `frameStart` high clears the register, the error flag and the shifted-bit count to zero on the next edge, whatever `bitValid` and `phaseSel` hold in that cycle.
- R3: In the accumulate phase (`phaseSel` = 2'b00), each valid bit forms `bitIn` XOR register bit 14. The register then shifts left by one with a 0 fill, and is XORed with 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1) when that XOR is 1. A frame holding the single bit 1 therefore yields 0x4599.
- R4: A cycle with `bitValid` low changes neither the register, the error flag nor the count, so stuff bits withheld this way never reach the checksum.
- R5: `crcBitOut` always shows register bit 14. In the shift-out phase (`phaseSel` = 2'b01), each valid strobe shifts the register left by one with a 0 fill, so 15 strobes deliver the checksum most significant bit first.
- R6: In the compare phase (`phaseSel` = 2'b10), each valid strobe compares `crcBitIn` with `crcBitOut` and then shifts as in R5. A mismatch sets `crcError`, which stays set until the next `frameStart`.
- R7: Once 15 bits have been shifted or compared since `frameStart`, further strobes in either phase are ignored. `crcBitOut` stays at 0 and no new error is raised.
- R8: The hold phase (`phaseSel` = 2'b11) leaves the register, count and error flag unchanged even with `bitValid` high.
- R9: Accumulating a message followed by its own 15 checksum bits, most significant first, leaves the register at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitValid | input | 1 | Strobe marking a destuffed bit to act on |
| frameStart | input | 1 | Synchronous clear at start of frame |
| phaseSel | input | 2 | 00 accumulate, 01 shift out, 10 compare, 11 hold |
| bitIn | input | 1 | Destuffed frame bit for accumulation |
| crcBitIn | input | 1 | Received CRC field bit for comparison |
| crcBitOut | output | 1 | Current checksum bit, most significant first |
| crcError | output | 1 | Sticky checksum mismatch flag |

## Verification
The assertions assume the caller does not go back to the accumulate phase once shifting or comparing has begun within a frame. They also assume `phaseSel` only takes its four defined codes. The stimulus follows the order the frame parser would use: clear, then accumulate, then one of shift or compare, with hold phases and low-strobe gaps placed only between bits. Inputs are driven at the falling edge, so no property sees an input change at the sampling edge.

// File: rtl/frame_crc_pkg.sv
package frame_crc_pkg;

  typedef enum logic [1:0] {
    PH_ACCUM = 2'b00,
    PH_SHIFT = 2'b01,
    PH_CHECK = 2'b10,
    PH_HOLD  = 2'b11
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic accum;
    logic advance;
    logic check;
  } crc_strobe_t;

endpackage

// File: rtl/frame_crc_ctrl.sv
module frame_crc_ctrl
  import frame_crc_pkg::*;
#(
  parameter int CRC_W = 15,
  parameter int CNT_W = $clog2(CRC_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             frameStart,
  input  phase_e           phase,
  output crc_strobe_t      strobe,
  output logic [CNT_W-1:0] shiftCnt
);

  localparam logic [CNT_W-1:0] FIELD_LEN = CNT_W'(CRC_W);

  logic fieldOpen;
  assign fieldOpen = (shiftCnt < FIELD_LEN);

  always_comb begin
    strobe       = '0;
    strobe.clear = frameStart;
    if (!frameStart && bitValid) begin
      unique case (phase)
        PH_ACCUM: strobe.accum = 1'b1;
        PH_SHIFT: strobe.advance = fieldOpen;
        PH_CHECK: begin
          strobe.advance = fieldOpen;
          strobe.check   = fieldOpen;
        end
        PH_HOLD:  ;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftCnt <= '0;
    end else if (strobe.clear) begin
      shiftCnt <= '0;
    end else if (strobe.advance) begin
      shiftCnt <= shiftCnt + 1'b1;
    end
  end

endmodule

// File: rtl/frame_crc_dp.sv
module frame_crc_dp
  import frame_crc_pkg::*;
#(
  parameter int                 CRC_W = 15,
  parameter logic [CRC_W-1:0]   POLY  = 15'h4599
) (
  input  logic             clk,
  input  logic             rstN,
  input  crc_strobe_t      strobe,
  input  logic             bitIn,
  input  logic             crcBitIn,
  output logic [CRC_W-1:0] crcState,
  output logic             crcBitOut,
  output logic             crcError
);

  logic             feedback;
  logic [CRC_W-1:0] shifted;
  logic [CRC_W-1:0] nextAccum;
  logic             mismatch;

  assign crcBitOut = crcState[CRC_W-1];
  assign feedback  = bitIn ^ crcState[CRC_W-1];
  assign shifted   = {crcState[CRC_W-2:0], 1'b0};
  assign nextAccum = shifted ^ (feedback ? POLY : '0);
  assign mismatch  = strobe.check && (crcBitIn != crcState[CRC_W-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcState <= '0;
    end else if (strobe.clear) begin
      crcState <= '0;
    end else if (strobe.accum) begin
      crcState <= nextAccum;
    end else if (strobe.advance) begin
      crcState <= shifted;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcError <= 1'b0;
    end else if (strobe.clear) begin
      crcError <= 1'b0;
    end else if (mismatch) begin
      crcError <= 1'b1;
    end
  end

endmodule

// File: rtl/frame_crc15.sv
module frame_crc15
  import frame_crc_pkg::*;
#(
  parameter int               CRC_W = 15,
  parameter logic [CRC_W-1:0] POLY  = 15'h4599
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitValid,
  input  logic       frameStart,
  input  logic [1:0] phaseSel,
  input  logic       bitIn,
  input  logic       crcBitIn,
  output logic       crcBitOut,
  output logic       crcError
);

  localparam int CNT_W = $clog2(CRC_W + 1);

  phase_e           phase;
  crc_strobe_t      strobe;
  logic [CNT_W-1:0] shiftCnt;
  logic [CRC_W-1:0] crcState;

  assign phase = phase_e'(phaseSel);

  frame_crc_ctrl #(.CRC_W(CRC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitValid   (bitValid),
    .frameStart (frameStart),
    .phase      (phase),
    .strobe     (strobe),
    .shiftCnt   (shiftCnt)
  );

  frame_crc_dp #(.CRC_W(CRC_W), .POLY(POLY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bitIn     (bitIn),
    .crcBitIn  (crcBitIn),
    .crcState  (crcState),
    .crcBitOut (crcBitOut),
    .crcError  (crcError)
  );

endmodule

// File: rtl/frame_crc15_checker.sv
module frame_crc15_checker #(
  parameter int CRC_W = 15,
  parameter int CNT_W = $clog2(CRC_W + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitValid,
  input logic             frameStart,
  input logic [1:0]       phaseSel,
  input logic             crcBitIn,
  input logic             crcBitOut,
  input logic             crcError,
  input logic [CRC_W-1:0] crcState,
  input logic [CNT_W-1:0] shiftCnt
);

  localparam logic [CNT_W-1:0] FIELD_LEN = CNT_W'(CRC_W);

  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (!crcError && crcState == '0 && shiftCnt == '0));

  p_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && !bitValid) |=>
      ($stable(crcState) && $stable(crcError) && $stable(shiftCnt)));

  p_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && bitValid && phaseSel == 2'b01 && shiftCnt < FIELD_LEN) |=>
      (crcState == {$past(crcState[CRC_W-2:0]), 1'b0}));

  p_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && bitValid && phaseSel == 2'b10 && shiftCnt < FIELD_LEN &&
     crcBitIn != crcBitOut) |=> crcError);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (crcError && !frameStart) |=> crcError);

  p_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcError) |-> $past(bitValid && phaseSel == 2'b10));

  p_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    shiftCnt <= FIELD_LEN);

  p_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && shiftCnt == FIELD_LEN && phaseSel != 2'b00) |=>
      ($stable(crcState) && $stable(crcError)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && phaseSel == 2'b11) |=>
      ($stable(crcState) && $stable(crcError) && $stable(shiftCnt)));

endmodule

bind frame_crc15 frame_crc15_checker #(.CRC_W(CRC_W), .CNT_W(CNT_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .bitValid   (bitValid),
  .frameStart (frameStart),
  .phaseSel   (phaseSel),
  .crcBitIn   (crcBitIn),
  .crcBitOut  (crcBitOut),
  .crcError   (crcError),
  .crcState   (crcState),
  .shiftCnt   (shiftCnt)
);

// File: tb/frame_crc15_bench.sv
module frame_crc15_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       bitValid;
  logic       frameStart;
  logic [1:0] phaseSel;
  logic       bitIn;
  logic       crcBitIn;
  logic       crcBitOut;
  logic       crcError;

  int checks = 0;
  int errors = 0;
  int seed   = 32'h1234_5678;

  bit mq[$];
  int mCnt = 0;
  bit mErr = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_crc15 u_frame_crc15 (
    .clk        (clk),
    .rstN       (rstN),
    .bitValid   (bitValid),
    .frameStart (frameStart),
    .phaseSel   (phaseSel),
    .bitIn      (bitIn),
    .crcBitIn   (crcBitIn),
    .crcBitOut  (crcBitOut),
    .crcError   (crcError)
  );

  // Long division of the message followed by 15 zeros
  function automatic int refCrc();
    int r = 0;
    for (int i = 0; i < mq.size() + 15; i++) begin
      r = (r << 1) | ((i < mq.size()) ? int'(mq[i]) : 0);
      if ((r & 'h8000) != 0) r = r ^ 'hC599;
    end
    return r & 'h7FFF;
  endfunction

  function automatic bit expOut();
    if (mCnt >= 15) return 1'b0;
    return bit'((refCrc() >> (14 - mCnt)) & 1);
  endfunction

  function bit nextBit();
    seed = seed * 1103515245 + 12345;
    return seed[16];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(input bit fs, input bit v, input bit b, input bit cb,
                      input bit [1:0] ph, input string tag);
    bit eo;
    frameStart = fs; bitValid = v; bitIn = b; crcBitIn = cb; phaseSel = ph;
    eo = expOut();
    @(posedge clk);
    if (fs) begin
      mq.delete(); mCnt = 0; mErr = 1'b0;
    end else if (v) begin
      case (ph)
        2'b00: mq.push_back(b);
        2'b01: if (mCnt < 15) mCnt++;
        2'b10: if (mCnt < 15) begin
          if (cb != eo) mErr = 1'b1;
          mCnt++;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    check(tag, crcBitOut, expOut(), "crcBitOut");
    check(tag, crcError, mErr, "crcError");
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [14:0] got;
    int c;
    rstN = 1'b0; frameStart = 0; bitValid = 0; bitIn = 0; crcBitIn = 0; phaseSel = 2'b11;
    repeat (3) @(negedge clk);
    check("R1", crcBitOut, 1'b0, "reset crcBitOut");
    check("R1", crcError, 1'b0, "reset crcError");
    rstN = 1'b1;
    @(negedge clk);

    // R3: known value for a single one bit
    tick(1, 0, 0, 0, 2'b00, "R2");
    tick(0, 1, 1, 0, 2'b00, "R3");
    for (int k = 0; k < 15; k++) begin
      got[14 - k] = crcBitOut;
      tick(0, 1, 0, 0, 2'b01, "R5");
    end
    checks++;
    if (got !== 15'h4599) begin
      errors++;
      $display("FAIL R3 single-bit checksum actual %h expected 4599", got);
    end

    // Frame A: accumulate with gaps and holds, then shift out and overrun
    tick(1, 0, 0, 0, 2'b00, "R2");
    for (int i = 0; i < 19; i++) begin
      tick(0, 1, nextBit(), 0, 2'b00, "R3");
      if (i % 5 == 4) tick(0, 0, ~mq[mq.size()-1], 1, 2'b00, "R4");
    end
    for (int i = 0; i < 3; i++) tick(0, 1, 1, 1, 2'b11, "R8");
    for (int i = 0; i < 15; i++) begin
      tick(0, 1, 0, 0, 2'b01, "R5");
      if (i == 6) tick(0, 0, 1, 1, 2'b01, "R4");
    end
    for (int i = 0; i < 3; i++) tick(0, 1, 1, 1, 2'b01, "R7");

    // Frame B: clear with strobe active, compare correct bits, overrun with ones
    tick(1, 1, 1, 1, 2'b00, "R2");
    for (int i = 0; i < 40; i++) tick(0, 1, nextBit(), 0, 2'b00, "R3");
    for (int i = 0; i < 15; i++) tick(0, 1, 0, expOut(), 2'b10, "R6");
    for (int i = 0; i < 3; i++) tick(0, 1, 0, 1, 2'b10, "R7");

    // Frame C: one corrupted bit, error stays set
    tick(1, 0, 0, 0, 2'b00, "R2");
    for (int i = 0; i < 27; i++) tick(0, 1, nextBit(), 0, 2'b00, "R3");
    for (int i = 0; i < 15; i++) tick(0, 1, 0, (i == 7) ? ~expOut() : expOut(), 2'b10, "R6");
    tick(0, 1, 0, 0, 2'b11, "R6");
    tick(1, 0, 0, 0, 2'b00, "R2");

    // R9: message followed by its own checksum leaves zero
    for (int i = 0; i < 30; i++) tick(0, 1, nextBit(), 0, 2'b00, "R3");
    c = refCrc();
    for (int k = 14; k >= 0; k--) tick(0, 1, bit'((c >> k) & 1), 0, 2'b00, "R9");
    for (int k = 0; k < 15; k++) begin
      got[14 - k] = crcBitOut;
      tick(0, 1, 0, 0, 2'b01, "R9");
    end
    checks++;
    if (got !== 15'h0) begin
      errors++;
      $display("FAIL R9 residue actual %h expected 0000", got);
    end

    summary();
    $finish;
  end

endmodule